// File: doc/BRIEF.md
# Prioritized Load/Shift Register

This block is a clocked register of parameterized width, four bits by default, with three independent control inputs: parallel load, shift right and shift left. The three controls are not mutually exclusive. A small priority decoder resolves them into one operation per cycle. Load wins over both shifts. Shift right wins over shift left. With no control raised, the register holds its value.

The decoded operation drives a four-way choice in front of every flip-flop. The choices are hold, take the parallel input, take the left-hand neighbour (shift right), or take the right-hand neighbour (shift left). A serial bit fills the end position that a shift vacates.

Typical uses are a sampler that captures a value on demand, or a serializer that is loaded and then shifted. Every operation takes effect on the rising clock edge. An active-low asynchronous reset clears the contents.

Top module: `prio_shift_reg`

## Requirements
- R1: When `load_i` is 1 at a rising edge, `q_o` takes `data_i` on that edge, whatever the two shift inputs are.
- R2: When `load_i` is 0 and `sh_right_i` is 1 at a rising edge, bit k of `q_o` takes the old bit k+1, and bit W-1 takes `ser_right_i`, whatever `sh_left_i` is.
- R3: When `load_i` and `sh_right_i` are 0 and `sh_left_i` is 1 at a rising edge, bit k of `q_o` takes the old bit k-1, and bit 0 takes `ser_left_i`.
- R4: When all three controls are 0 at a rising edge, `q_o` keeps its value, regardless of `data_i` and both serial inputs.
- R5: While `rst_ni` is 0, `q_o` is all zeros at once, without waiting for a clock edge, and the reset overrides every control.
- R6: R1 to R4 hold for any width W of 2 or more, including widths other than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all operations occur on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the register |
| load_i | input | 1 | Parallel load request (highest priority) |
| sh_right_i | input | 1 | Shift toward bit 0 request (second priority) |
| sh_left_i | input | 1 | Shift toward bit W-1 request (lowest priority) |
| data_i | input | W | Parallel input value |
| ser_right_i | input | 1 | Bit entering position W-1 on a right shift |
| ser_left_i | input | 1 | Bit entering position 0 on a left shift |
| q_o | output | W | Register contents |

## Verification
The 4-bit register is swept over every combination of the following:
- starting contents,
- all eight settings of the three controls,
- every parallel input value,
- all four pairs of serial bits.

The sweep is decisive for the priority rules. Cases where a loser's inputs would change the result expose any wrong priority order. Nonzero data and serial inputs during hold expose any leak into a held register.

Varying the serial bits against all-zero and all-one contents tells a wrong end position apart from a missing serial entry. A 7-bit instance gets the same controls with mixed contents, which catches end-bit indexing that only works at width 4. Reset is asserted between clock edges to show that clearing does not wait for the clock.

// File: rtl/prio_shift_reg_pkg.sv
package prio_shift_reg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_SHR   = 2'b10,
    OP_SHL   = 2'b11
  } reg_op_e;
endpackage

// File: rtl/prio_op_dec.sv
module prio_op_dec
  import prio_shift_reg_pkg::*;
(
  input  logic    load_i,
  input  logic    sh_right_i,
  input  logic    sh_left_i,
  output reg_op_e op_o
);
  // fixed priority: load > right > left > hold
  always_comb begin
    if (load_i)          op_o = OP_LOAD;
    else if (sh_right_i) op_o = OP_SHR;
    else if (sh_left_i)  op_o = OP_SHL;
    else                 op_o = OP_HOLD;
  end
endmodule

// File: rtl/prio_next_val.sv
module prio_next_val
  import prio_shift_reg_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  reg_op_e        op_i,
  input  logic [W-1:0]   cur_i,
  input  logic [W-1:0]   data_i,
  input  logic           ser_right_i,
  input  logic           ser_left_i,
  output logic [W-1:0]   nxt_o
);
  localparam int unsigned MSB = W - 1;

  for (genvar k = 0; k < W; k++) begin : g_bit
    logic from_hi;
    logic from_lo;

    if (k == MSB) begin : g_top
      assign from_hi = ser_right_i;
    end else begin : g_mid_hi
      assign from_hi = cur_i[k+1];
    end

    if (k == 0) begin : g_bot
      assign from_lo = ser_left_i;
    end else begin : g_mid_lo
      assign from_lo = cur_i[k-1];
    end

    always_comb begin
      unique case (op_i)
        OP_LOAD: nxt_o[k] = data_i[k];
        OP_SHR:  nxt_o[k] = from_hi;
        OP_SHL:  nxt_o[k] = from_lo;
        default: nxt_o[k] = cur_i[k];
      endcase
    end
  end
endmodule

// File: rtl/prio_shift_reg.sv
module prio_shift_reg
  import prio_shift_reg_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         sh_right_i,
  input  logic         sh_left_i,
  input  logic [W-1:0] data_i,
  input  logic         ser_right_i,
  input  logic         ser_left_i,
  output logic [W-1:0] q_o
);
  reg_op_e      op;
  logic [W-1:0] nxt;
  logic [W-1:0] q_q;

  prio_op_dec u_dec (
    .load_i     (load_i),
    .sh_right_i (sh_right_i),
    .sh_left_i  (sh_left_i),
    .op_o       (op)
  );

  prio_next_val #(.W(W)) u_nxt (
    .op_i        (op),
    .cur_i       (q_q),
    .data_i      (data_i),
    .ser_right_i (ser_right_i),
    .ser_left_i  (ser_left_i),
    .nxt_o       (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= nxt;
  end

  assign q_o = q_q;
endmodule

// File: rtl/prio_shift_reg_chk.sv
module prio_shift_reg_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_i,
  input logic         sh_right_i,
  input logic         sh_left_i,
  input logic [W-1:0] data_i,
  input logic         ser_right_i,
  input logic         ser_left_i,
  input logic [W-1:0] q_o
);
  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(data_i));

  p_shr_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && sh_right_i) |=> q_o == {$past(ser_right_i), $past(q_o[W-1:1])});

  p_shl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !sh_right_i && sh_left_i) |=> q_o == {$past(q_o[W-2:0]), $past(ser_left_i)});

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !sh_right_i && !sh_left_i) |=> $stable(q_o));

  p_reset_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> q_o == '0);
endmodule

bind prio_shift_reg prio_shift_reg_chk #(.W(W)) u_chk (.*);

// File: tb/prio_shift_reg_bench.sv
`timescale 1ns/1ps
module prio_shift_reg_bench;
  localparam int unsigned WA = 4;
  localparam int unsigned WB = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 1'b0, sr = 1'b0, sl = 1'b0, bin_r = 1'b0, bin_l = 1'b0;
  logic [WA-1:0] da = '0;
  logic [WB-1:0] db = '0;
  logic [WA-1:0] qa;
  logic [WB-1:0] qb;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  prio_shift_reg #(.W(WA)) u_prio_shift_reg (
    .clk_i(clk), .rst_ni(rst_n), .load_i(ld), .sh_right_i(sr), .sh_left_i(sl),
    .data_i(da), .ser_right_i(bin_r), .ser_left_i(bin_l), .q_o(qa));

  prio_shift_reg #(.W(WB)) u_prio_shift_reg_w7 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(ld), .sh_right_i(sr), .sh_left_i(sl),
    .data_i(db), .ser_right_i(bin_r), .ser_left_i(bin_l), .q_o(qb));

  function automatic int unsigned model(int unsigned q, bit l, bit r, bit s,
                                        int unsigned d, bit ir, bit il, int w);
    int unsigned mask = (32'd1 << w) - 1;
    if (l)      return d & mask;
    else if (r) return (q >> 1) | (int'(ir) << (w - 1));
    else if (s) return ((q << 1) | int'(il)) & mask;
    else        return q & mask;
  endfunction

  task automatic chk(string req, int unsigned act, int unsigned exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    // R5: reset state, held across edges
    repeat (3) @(negedge clk);
    chk("R5", qa, 0);
    chk("R5", qb, 0);
    rst_n = 1'b1;

    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 8; c++)
        for (int d = 0; d < 16; d++)
          for (int b = 0; b < 4; b++) begin
            int unsigned s7, d7, ea, eb;
            string tag;
            s7 = (s << 3) | (d & 7);
            d7 = (d << 3) | ((s ^ 5) & 7);
            // set starting contents
            ld = 1'b1; sr = 1'b0; sl = 1'b0;
            da = WA'(s); db = WB'(s7);
            @(negedge clk);
            ld = c[2]; sr = c[1]; sl = c[0];
            da = WA'(d); db = WB'(d7);
            bin_r = b[1]; bin_l = b[0];
            @(negedge clk);
            ea = model(s, c[2], c[1], c[0], d, b[1], b[0], WA);
            eb = model(s7, c[2], c[1], c[0], d7, b[1], b[0], WB);
            tag = c[2] ? "R1" : c[1] ? "R2" : c[0] ? "R3" : "R4";
            chk(tag, qa, ea);
            chk({tag, "/R6"}, qb, eb);
          end

    // R5: asynchronous clear between edges, controls busy
    ld = 1'b1; da = 4'hF; db = 7'h7F;
    @(negedge clk);
    ld = 1'b1; sr = 1'b1; sl = 1'b1;
    #1 rst_n = 1'b0;
    #0.5;
    chk("R5", qa, 0);
    chk("R5", qb, 0);
    @(negedge clk);
    chk("R5", qa, 0);
    rst_n = 1'b1;
    ld = 1'b0; sr = 1'b0; sl = 1'b0;
    @(negedge clk);
    chk("R5", qa, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule